// File: doc/BRIEF.md
# Storage-Bus Controller Host Register Block

This block is the byte-wide host-facing register set of a storage-bus controller. A host processor reaches sixteen byte offsets through an address, a write-data byte, a read-data byte and separate read and write strobes. Several offsets lead to one register on a write and to another on a read. Writing the command offset decodes an opcode at once. The opcode updates the status, interrupt-cause, sequence-step and FIFO-flag registers and may raise the single interrupt line.

Target selection and data transfer are reduced to one-cycle request strobes. A selection command checks the addressed target ID against a presence mask supplied at an input and answers alone when that target is missing. Reading the interrupt-cause offset is the host's acknowledge. The read returns the pending cause, then clears the cause and the terminal-count flag, sets the sequence step to 4 and drops the interrupt.

Top module: `sbc_host_regs`

## Requirements
- R1: After reset, offsets 0x3, 0x4, 0x5, 0x6 and 0x7 read 0x00, offset 0x8 (config1) reads 0x07, offset 0xE (chip ID) reads 0x04, and irq, dma_mode, sel_req and xfer_req are low.
- R2: A write to offset 0x3 latches the command byte, which reads back at offset 0x3. Bit 7 of the latched byte drives dma_mode and bits [6:0] are the opcode. An unknown opcode, or opcode 0x1A, changes no other register and leaves irq unchanged.
- R3: A read of offset 0x5 returns the cause value held before the read. Afterwards the cause is 0x00, status bit 4 (terminal count) is 0, the sequence step (offset 0x6) is 4 and irq is low.
- R4: Bit 7 of the status register (offset 0x4) reads 1 exactly when irq is high.
- R5: Opcode 0x03 sets the cause to 0x80 and raises irq only when config1 bit 6 is 0.
- R6: Opcode 0x01 sets the cause to 0x08 and clears the sequence step and the flags (offset 0x7), leaving irq unchanged.
- R7: Opcode 0x18 sets status bits [6:0] to 0x10, the cause to 0x08 and the sequence step to 0, without raising irq. Opcode 0x44 clears the cause.
- R8: Opcodes 0x41, 0x42 and 0x43 address the target ID held in bits [2:0] of the byte last written to offset 0x4. An ID that is not below NUM_TGT, or whose tgt_present bit is 0, gives status bits [6:0] = 0, cause 0x20, sequence step 0, raises irq and produces no sel_req.
- R9: Selecting a present target pulses sel_req for one cycle, with sel_id equal to the ID. Opcode 0x43 also sets status bits [6:0] to 0x12, the cause to 0x18 and the sequence step to 4, and raises irq. Opcodes 0x41 and 0x42 leave irq unchanged.
- R10: Opcode 0x10 pulses xfer_req for one cycle.
- R11: Opcode 0x11 with bit 7 clear sets the flags to 2 and the cause to 0x08, ORs 0x07 into status bits [2:0], keeps the sequence step and raises irq. With bit 7 set it sets status bits [6:0] to 0x17, the cause to 0x08 and the sequence step to 4, keeps the flags and raises irq.
- R12: Opcode 0x12 sets the cause to 0x20 and the sequence step to 0 and raises irq. With bit 7 clear it also sets the flags to 2 and keeps the status. With bit 7 set it sets status bits [6:0] to 0x13.
- R13: Opcode 0x02 returns every register, including the command byte, config1 and the stored target ID, to its reset value, and drops irq.
- R14: Offsets 0x4 and 0x5 are write-only on the write side. Writing them leaves the values read back at those offsets unchanged, and config1 written at offset 0x8 reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle that bus_rd is high |
| tgt_present | input | NUM_TGT | One bit per target ID, 1 when the target exists |
| irq | output | 1 | Interrupt request, level |
| dma_mode | output | 1 | Bit 7 of the latched command byte |
| sel_req | output | 1 | One-cycle selection request |
| sel_id | output | 3 | Target ID for the selection request |
| xfer_req | output | 1 | One-cycle transfer-information request |

## Verification
The bench builds the block with NUM_TGT set to 6 and a presence mask in which only IDs 0 and 2 exist. With this setting the out-of-range path (ID 7), the absent-but-in-range path (ID 1) and the present path (IDs 0 and 2) all occur on one instance. The interrupt acknowledge is exercised after every interrupting command, so the terminal-count clear and the sequence-step reset are seen from several different status values. Each response command is issued with bit 7 both clear and set.

// File: rtl/sbc_regs_pkg.sv
package sbc_regs_pkg;

  localparam int REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] OFS_CMD    = 4'h3;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT   = 4'h4;  // write side: target ID
  localparam logic [REG_ADDR_W-1:0] OFS_INTR   = 4'h5;  // write side: select timeout
  localparam logic [REG_ADDR_W-1:0] OFS_SEQ    = 4'h6;
  localparam logic [REG_ADDR_W-1:0] OFS_FLAGS  = 4'h7;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG1   = 4'h8;
  localparam logic [REG_ADDR_W-1:0] OFS_CHIPID = 4'hE;

  localparam logic [7:0] CAUSE_FUNC = 8'h08;
  localparam logic [7:0] CAUSE_SVC  = 8'h10;
  localparam logic [7:0] CAUSE_DISC = 8'h20;
  localparam logic [7:0] CAUSE_BRST = 8'h80;

  localparam int         ST_TC_BIT  = 4;
  localparam logic [2:0] PH_CMD     = 3'd2;
  localparam logic [2:0] PH_STATUS  = 3'd3;
  localparam logic [2:0] PH_MSGIN   = 3'd7;

  localparam logic [2:0] SEQ_DONE   = 3'd4;
  localparam int         CFG1_QUIET_BIT = 6;

  typedef enum logic [3:0] {
    OP_IDLE, OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER,
    OP_CMPLT, OP_MSGOK, OP_PAD, OP_ATN, OP_SEL, OP_SELSTOP,
    OP_ENSEL, OP_UNKNOWN
  } op_e;

  function automatic op_e decode_op(input logic [6:0] code);
    case (code)
      7'h00:        return OP_NOP;
      7'h01:        return OP_FLUSH;
      7'h02:        return OP_CHIPRST;
      7'h03:        return OP_BUSRST;
      7'h10:        return OP_XFER;
      7'h11:        return OP_CMPLT;
      7'h12:        return OP_MSGOK;
      7'h18:        return OP_PAD;
      7'h1A:        return OP_ATN;
      7'h41, 7'h42: return OP_SEL;
      7'h43:        return OP_SELSTOP;
      7'h44:        return OP_ENSEL;
      default:      return OP_UNKNOWN;
    endcase
  endfunction

  // Status low bits after the command-complete sequence.
  function automatic logic [6:0] cmplt_status(input logic dma, input logic [6:0] cur);
    logic [6:0] tc_st;
    tc_st = 7'(1 << ST_TC_BIT) | {4'b0, PH_STATUS};
    if (dma) return tc_st | {4'b0, PH_MSGIN};
    return cur | {4'b0, PH_MSGIN};
  endfunction

  // Status low bits after message accepted.
  function automatic logic [6:0] msgok_status(input logic dma, input logic [6:0] cur);
    if (dma) return 7'(1 << ST_TC_BIT) | {4'b0, PH_STATUS};
    return cur;
  endfunction

  function automatic logic [6:0] stop_status();
    return 7'(1 << ST_TC_BIT) | {4'b0, PH_CMD};
  endfunction

endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_regs_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output op_e        op,
  output logic       dma_bit
);

  always_comb begin
    op      = cmd_wr ? decode_op(cmd_byte[6:0]) : OP_IDLE;
    dma_bit = cmd_byte[7];
  end

endmodule

// File: rtl/sbc_tgt_check.sv
module sbc_tgt_check #(
  parameter int NUM_TGT = 8
) (
  input  logic [2:0]         id,
  input  logic [NUM_TGT-1:0] mask,
  output logic               present
);

  localparam int ID_SPACE = 8;

  logic [ID_SPACE-1:0] wide_mask;

  for (genvar i = 0; i < ID_SPACE; i++) begin : g_bit
    if (i < NUM_TGT) begin : g_in
      assign wide_mask[i] = mask[i];
    end else begin : g_out
      assign wide_mask[i] = 1'b0;
    end
  end

  assign present = wide_mask[id];

endmodule

// File: rtl/sbc_irq_ctrl.sv
module sbc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic lower,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (lower)  irq_q <= 1'b0;
    else if (raise)  irq_q <= 1'b1;
  end

  assign irq = irq_q;

  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && !lower) |=> irq);

  assert_irq_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lower |=> !irq);

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise && !lower) |=> $stable(irq));

endmodule

// File: rtl/sbc_host_regs.sv
module sbc_host_regs
  import sbc_regs_pkg::*;
#(
  parameter int         NUM_TGT  = 8,
  parameter logic [7:0] CHIP_ID  = 8'h04,
  parameter logic [7:0] CFG1_RST = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic               irq,
  output logic               dma_mode,
  output logic               sel_req,
  output logic [2:0]         sel_id,
  output logic               xfer_req
);

  localparam int ID_W = 3;

  // state
  logic [7:0]      cmd_q, cause_q, flags_q, cfg1_q;
  logic [6:0]      stat_lo_q;
  logic [2:0]      seq_q;
  logic [ID_W-1:0] busid_q, sel_id_q;
  logic            sel_req_q, xfer_req_q;

  logic [7:0]      cmd_n, cause_n, flags_n, cfg1_n;
  logic [6:0]      stat_lo_n;
  logic [2:0]      seq_n;
  logic [ID_W-1:0] busid_n, sel_id_n;
  logic            sel_req_n, xfer_req_n;
  logic            irq_raise, irq_lower;

  // named events
  logic ev_cmd_wr, ev_rd_intr, ev_busrst, ev_chiprst, ev_sel_absent, ev_xfer;
  op_e  op;
  logic op_dma, tgt_ok, is_select;

  assign ev_cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
  assign ev_rd_intr = bus_rd && !bus_wr && (bus_addr == OFS_INTR);

  sbc_cmd_decode u_dec (
    .cmd_wr   (ev_cmd_wr),
    .cmd_byte (bus_wdata),
    .op       (op),
    .dma_bit  (op_dma)
  );

  sbc_tgt_check #(.NUM_TGT(NUM_TGT)) u_tgt (
    .id      (busid_q),
    .mask    (tgt_present),
    .present (tgt_ok)
  );

  sbc_irq_ctrl u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (irq_raise),
    .lower (irq_lower),
    .irq   (irq)
  );

  assign is_select     = (op == OP_SEL) || (op == OP_SELSTOP);
  assign ev_busrst     = (op == OP_BUSRST);
  assign ev_chiprst    = (op == OP_CHIPRST);
  assign ev_sel_absent = is_select && !tgt_ok;
  assign ev_xfer       = (op == OP_XFER);

  always_comb begin
    cmd_n      = cmd_q;
    cause_n    = cause_q;
    flags_n    = flags_q;
    cfg1_n     = cfg1_q;
    stat_lo_n  = stat_lo_q;
    seq_n      = seq_q;
    busid_n    = busid_q;
    sel_id_n   = sel_id_q;
    sel_req_n  = 1'b0;
    xfer_req_n = 1'b0;
    irq_raise  = 1'b0;
    irq_lower  = 1'b0;

    if (bus_wr) begin
      case (bus_addr)
        OFS_STAT: busid_n = bus_wdata[ID_W-1:0];
        OFS_CFG1: cfg1_n  = bus_wdata;
        OFS_CMD:  cmd_n   = bus_wdata;
        default: ;
      endcase

      case (op)
        OP_FLUSH: begin
          cause_n = CAUSE_FUNC;
          seq_n   = '0;
          flags_n = '0;
        end
        OP_CHIPRST: begin
          cmd_n     = '0;
          cause_n   = '0;
          flags_n   = '0;
          cfg1_n    = CFG1_RST;
          stat_lo_n = '0;
          seq_n     = '0;
          busid_n   = '0;
          irq_lower = 1'b1;
        end
        OP_BUSRST: begin
          cause_n   = CAUSE_BRST;
          irq_raise = !cfg1_q[CFG1_QUIET_BIT];
        end
        OP_XFER: xfer_req_n = 1'b1;
        OP_CMPLT: begin
          stat_lo_n = cmplt_status(op_dma, stat_lo_q);
          cause_n   = CAUSE_FUNC;
          if (op_dma) seq_n   = SEQ_DONE;
          else        flags_n = 8'd2;
          irq_raise = 1'b1;
        end
        OP_MSGOK: begin
          stat_lo_n = msgok_status(op_dma, stat_lo_q);
          cause_n   = CAUSE_DISC;
          seq_n     = '0;
          if (!op_dma) flags_n = 8'd2;
          irq_raise = 1'b1;
        end
        OP_PAD: begin
          stat_lo_n = 7'(1 << ST_TC_BIT);
          cause_n   = CAUSE_FUNC;
          seq_n     = '0;
        end
        OP_ENSEL: cause_n = '0;
        OP_SEL, OP_SELSTOP: begin
          if (!tgt_ok) begin
            stat_lo_n = '0;
            cause_n   = CAUSE_DISC;
            seq_n     = '0;
            irq_raise = 1'b1;
          end else begin
            sel_req_n = 1'b1;
            sel_id_n  = busid_q;
            if (op == OP_SELSTOP) begin
              stat_lo_n = stop_status();
              cause_n   = CAUSE_SVC | CAUSE_FUNC;
              seq_n     = SEQ_DONE;
              irq_raise = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (ev_rd_intr) begin
      cause_n             = '0;
      stat_lo_n[ST_TC_BIT] = 1'b0;
      seq_n               = SEQ_DONE;
      irq_lower           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cause_q    <= '0;
      flags_q    <= '0;
      cfg1_q     <= CFG1_RST;
      stat_lo_q  <= '0;
      seq_q      <= '0;
      busid_q    <= '0;
      sel_id_q   <= '0;
      sel_req_q  <= 1'b0;
      xfer_req_q <= 1'b0;
    end else begin
      cmd_q      <= cmd_n;
      cause_q    <= cause_n;
      flags_q    <= flags_n;
      cfg1_q     <= cfg1_n;
      stat_lo_q  <= stat_lo_n;
      seq_q      <= seq_n;
      busid_q    <= busid_n;
      sel_id_q   <= sel_id_n;
      sel_req_q  <= sel_req_n;
      xfer_req_q <= xfer_req_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CMD:    bus_rdata = cmd_q;
        OFS_STAT:   bus_rdata = {irq, stat_lo_q};
        OFS_INTR:   bus_rdata = cause_q;
        OFS_SEQ:    bus_rdata = {5'b0, seq_q};
        OFS_FLAGS:  bus_rdata = flags_q;
        OFS_CFG1:   bus_rdata = cfg1_q;
        OFS_CHIPID: bus_rdata = CHIP_ID;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign dma_mode = cmd_q[7];
  assign sel_req  = sel_req_q;
  assign sel_id   = sel_id_q;
  assign xfer_req = xfer_req_q;

  assert_intr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_intr |=> (cause_q == 8'h00 && seq_q == 3'd4 && !irq && !stat_lo_q[ST_TC_BIT]));

  assert_cmd_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_wr && !ev_chiprst) |=> (cmd_q == $past(bus_wdata)));

  assert_busrst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_busrst && cfg1_q[CFG1_QUIET_BIT]) |=> (cause_q == 8'h80 && irq == $past(irq)));

  assert_sel_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_absent |=> (irq && cause_q == 8'h20 && seq_q == 3'd0 && !sel_req));

  assert_chiprst_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chiprst |=> (cfg1_q == CFG1_RST && !irq && cmd_q == 8'h00));

  assert_xfer_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> xfer_req);

endmodule

// File: tb/sbc_host_regs_tb.sv
module sbc_host_regs_tb_top;

  localparam int NUM_TGT = 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [3:0]         bus_addr = '0;
  logic [7:0]         bus_wdata = '0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [7:0]         bus_rdata;
  logic [NUM_TGT-1:0] tgt_present = 6'b000101;
  logic               irq, dma_mode, sel_req, xfer_req;
  logic [2:0]         sel_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sbc_host_regs #(.NUM_TGT(NUM_TGT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tgt_present(tgt_present), .irq(irq), .dma_mode(dma_mode),
    .sel_req(sel_req), .sel_id(sel_id), .xfer_req(xfer_req)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("offset 0x%0h", a), v, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1", 4'h6, 8'h00);
    rd_chk("R1", 4'h7, 8'h00);
    rd_chk("R1", 4'h8, 8'h07);
    rd_chk("R1", 4'hE, 8'h04);
    rd_chk("R1", 4'h4, 8'h00);
    rd_chk("R1", 4'h3, 8'h00);
    chk("R1", "irq", {7'b0, irq}, 8'h00);
    chk("R1", "dma_mode", {7'b0, dma_mode}, 8'h00);
    chk("R1", "sel_req", {7'b0, sel_req}, 8'h00);
    chk("R1", "xfer_req", {7'b0, xfer_req}, 8'h00);
  endtask

  task automatic t_bus_reset();
    wr(4'h3, 8'h03);
    chk("R5", "irq after bus reset", {7'b0, irq}, 8'h01);
    rd_chk("R4", 4'h4, 8'h80);
    rd_chk("R3", 4'h5, 8'h80);
    chk("R3", "irq after ack", {7'b0, irq}, 8'h00);
    rd_chk("R3", 4'h6, 8'h04);
    rd_chk("R4", 4'h4, 8'h00);
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h03);
    chk("R5", "irq quiet bus reset", {7'b0, irq}, 8'h00);
    rd_chk("R14", 4'h8, 8'h47);
    rd_chk("R5", 4'h5, 8'h80);
    wr(4'h8, 8'h07);
  endtask

  task automatic t_sel_absent();
    wr(4'h4, 8'h01);
    rd_chk("R14", 4'h4, 8'h00);
    wr(4'h5, 8'h55);
    rd_chk("R14", 4'h5, 8'h00);
    wr(4'h3, 8'h42);
    chk("R8", "sel_req absent", {7'b0, sel_req}, 8'h00);
    chk("R8", "irq absent", {7'b0, irq}, 8'h01);
    rd_chk("R8", 4'h6, 8'h00);
    rd_chk("R8", 4'h4, 8'h80);
    rd_chk("R8", 4'h5, 8'h20);
    wr(4'h4, 8'h07);
    wr(4'h3, 8'h41);
    chk("R8", "sel_req out of range", {7'b0, sel_req}, 8'h00);
    chk("R8", "irq out of range", {7'b0, irq}, 8'h01);
    rd_chk("R8", 4'h5, 8'h20);
  endtask

  task automatic t_sel_present();
    wr(4'h4, 8'h02);
    wr(4'h3, 8'h41);
    chk("R9", "sel_req", {7'b0, sel_req}, 8'h01);
    chk("R9", "sel_id", {5'b0, sel_id}, 8'h02);
    chk("R9", "irq plain select", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R9", "sel_req one cycle", {7'b0, sel_req}, 8'h00);
    wr(4'h4, 8'h00);
    wr(4'h3, 8'h43);
    chk("R9", "sel_req stop", {7'b0, sel_req}, 8'h01);
    chk("R9", "sel_id stop", {5'b0, sel_id}, 8'h00);
    rd_chk("R9", 4'h4, 8'h92);
    rd_chk("R9", 4'h6, 8'h04);
    rd_chk("R9", 4'h5, 8'h18);
    rd_chk("R3", 4'h4, 8'h02);
  endtask

  task automatic t_complete_flush();
    wr(4'h3, 8'h11);
    rd_chk("R11", 4'h7, 8'h02);
    rd_chk("R11", 4'h4, 8'h87);
    rd_chk("R11", 4'h6, 8'h04);
    wr(4'h3, 8'h01);
    rd_chk("R6", 4'h6, 8'h00);
    rd_chk("R6", 4'h7, 8'h00);
    chk("R6", "irq kept", {7'b0, irq}, 8'h01);
    rd_chk("R6", 4'h5, 8'h08);
    wr(4'h3, 8'h91);
    chk("R2", "dma_mode set", {7'b0, dma_mode}, 8'h01);
    rd_chk("R11", 4'h4, 8'h97);
    rd_chk("R11", 4'h6, 8'h04);
    rd_chk("R11", 4'h7, 8'h00);
    rd_chk("R11", 4'h5, 8'h08);
  endtask

  task automatic t_msg_ok();
    wr(4'h3, 8'h12);
    chk("R2", "dma_mode clear", {7'b0, dma_mode}, 8'h00);
    rd_chk("R12", 4'h7, 8'h02);
    rd_chk("R12", 4'h4, 8'h87);
    rd_chk("R12", 4'h6, 8'h00);
    rd_chk("R12", 4'h5, 8'h20);
    wr(4'h3, 8'h92);
    rd_chk("R12", 4'h4, 8'h93);
    rd_chk("R12", 4'h6, 8'h00);
    rd_chk("R12", 4'h5, 8'h20);
  endtask

  task automatic t_pad_ensel();
    wr(4'h3, 8'h18);
    chk("R7", "irq after pad", {7'b0, irq}, 8'h00);
    rd_chk("R7", 4'h4, 8'h10);
    rd_chk("R7", 4'h6, 8'h00);
    rd_chk("R7", 4'h5, 8'h08);
    wr(4'h3, 8'h18);
    wr(4'h3, 8'h44);
    rd_chk("R7", 4'h5, 8'h00);
  endtask

  task automatic t_xfer_unknown();
    wr(4'h3, 8'h90);
    chk("R10", "xfer_req dma", {7'b0, xfer_req}, 8'h01);
    chk("R2", "dma_mode", {7'b0, dma_mode}, 8'h01);
    rd_chk("R2", 4'h3, 8'h90);
    wr(4'h3, 8'h10);
    chk("R10", "xfer_req", {7'b0, xfer_req}, 8'h01);
    @(negedge clk);
    chk("R10", "xfer_req one cycle", {7'b0, xfer_req}, 8'h00);
    wr(4'h3, 8'h2F);
    rd_chk("R2", 4'h3, 8'h2F);
    rd_chk("R2", 4'h4, 8'h00);
    rd_chk("R2", 4'h6, 8'h04);
    rd_chk("R2", 4'h7, 8'h02);
    chk("R2", "irq unknown op", {7'b0, irq}, 8'h00);
    wr(4'h3, 8'h1A);
    rd_chk("R2", 4'h3, 8'h1A);
    rd_chk("R2", 4'h6, 8'h04);
  endtask

  task automatic t_chip_reset();
    wr(4'h3, 8'h03);
    wr(4'h4, 8'h02);
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h82);
    chk("R13", "irq", {7'b0, irq}, 8'h00);
    chk("R13", "dma_mode", {7'b0, dma_mode}, 8'h00);
    rd_chk("R13", 4'h3, 8'h00);
    rd_chk("R13", 4'h8, 8'h07);
    rd_chk("R13", 4'h7, 8'h00);
    rd_chk("R13", 4'h6, 8'h00);
    rd_chk("R13", 4'h4, 8'h00);
    rd_chk("R13", 4'hE, 8'h04);
    wr(4'h3, 8'h41);
    chk("R13", "sel_req after reset", {7'b0, sel_req}, 8'h01);
    chk("R13", "sel_id cleared", {5'b0, sel_id}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_reset();
    t_sel_absent();
    t_sel_present();
    t_complete_flush();
    t_msg_ok();
    t_pad_ensel();
    t_xfer_unknown();
    t_chip_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule